// File: doc/BRIEF.md
# Receiver Front-End Control Register Bank

This block sits on a byte-wide host I/O bus and gives software control over the front end of a radio-navigation receiver. It decodes a 3-bit offset into eight register slots. The slots cover a mode/parameter byte, two 12-bit DAC holding registers, an 8-bit pulse-code buffer and a small controller for an external ADC. The parameter byte sets the integrator period, the gate source and a few enables. One of its bits chooses which half of a DAC a write lands in.

A DAC is loaded in two byte writes to the same offset. First the low byte is written with the half-select bit clear. Then the parameter byte is rewritten with the half-select bit set, and the top nibble is written. The analog output value moves only when the top nibble arrives, so a half-loaded code never appears.

The ADC controller has three parts. It latches a channel number, and it issues a one-cycle start pulse. It tracks busy and done. When the converter reports completion, it captures the converter's result. The completion raises an interrupt if interrupt enable is set, and reading the result clears that interrupt. The two lowest offsets are reserved for an external timing chip that is not part of this block.

Top module: `rxcard_regbank`

## Requirements
- R1: A write to offset 7 stores the parameter byte. Its fields drive the outputs as follows: bits [1:0] go to `integ_sel` (0 = 1000 us, 1 = 264 us, 2 = 36 us, 3 = short), bits [3:2] go to `gate_sel` (0 = open, 1 = group-repetition, 2 = envelope, 3 = strobe), bit 4 goes to `dac_hi_sel`, bit 5 goes to `irq_en`, bit 6 goes to `cnt5_en` and bit 7 goes to `grp_gate_en`. Writes to any other offset leave these outputs unchanged.
- R2: A write to offset 4 (DAC A) or offset 5 (DAC B) while `dac_hi_sel` is 0 holds data bits [7:0] as the pending low byte. The DAC output does not change.
- R3: A write to offset 4 or 5 while `dac_hi_sel` is 1 loads the DAC output in the same clock edge. The value loaded is data bits [3:0] as bits [11:8], with the pending low byte as bits [7:0]. The two DACs are fully independent.
- R4: A write to offset 2 sets `adc_chan` to data bits [1:0] (0 = I, 1 = Q, 2 = S).
- R5: A write to offset 3 with data bit 0 set, while the converter is idle, does three things: `adc_start` goes high for exactly one cycle after the write edge, busy is set and done is cleared. A write to offset 3 with bit 0 clear has no effect.
- R6: A read of offset 3 returns busy in bit 0 and done in bit 7, with all other bits 0. When `adc_done_in` is high while busy, the block captures `adc_result_in`, clears busy and sets done.
- R7: The captured result, read at offset 2, holds until the next conversion completes. A start request written while busy is ignored: no pulse is issued and the status does not change.
- R8: `irq` is high only while a completed result is pending and `irq_en` is 1. The pending state is cleared by a read of offset 2 or by an accepted start.
- R9: A write to offset 6 sets `pcode` to the data byte.
- R10: After reset, the outputs take these values: the parameter fields are 0, both DACs are 0x800, `pcode` is 0, `adc_chan` is 0, `adc_start` is 0, `irq` is 0 and the status reads 0.
- R11: Reads of offsets 0, 1, 4, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; side effects at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| adc_done_in | input | 1 | Converter completion pulse |
| adc_result_in | input | 8 | Converter result, valid with completion |
| adc_chan | output | 2 | Converter channel select |
| adc_start | output | 1 | One-cycle conversion start |
| integ_sel | output | 2 | Integrator period select |
| gate_sel | output | 2 | Gate source select |
| dac_hi_sel | output | 1 | DAC half select |
| irq_en | output | 1 | Interrupt enable |
| cnt5_en | output | 1 | Counter 5 enable |
| grp_gate_en | output | 1 | Group-repetition gate enable |
| dac_a | output | 12 | DAC A code |
| dac_b | output | 12 | DAC B code |
| pcode | output | 8 | Pulse-code buffer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 12-bit DACs resetting to mid-scale 0x800, an 8-bit result and a 2-bit channel. With these values the nibble split of the DAC is exact. The reset value is distinct from any code written later, so a premature or split DAC update shows up at the ports. The bench drives converter completion directly, so it can place completion next to starts, reads and enable changes. This exercises the ignored start while busy, the held result and the interrupt gating.

// File: rtl/rxcard_pkg.sv
package rxcard_pkg;
   localparam int unsigned OFS_W = 3;
   localparam logic [OFS_W-1:0] OFS_ADC_DATA = 3'd2;
   localparam logic [OFS_W-1:0] OFS_ADC_CTRL = 3'd3;
   localparam logic [OFS_W-1:0] OFS_DAC_BASE = 3'd4;
   localparam logic [OFS_W-1:0] OFS_PCODE    = 3'd6;
   localparam logic [OFS_W-1:0] OFS_PARAM    = 3'd7;

   typedef struct packed {
      logic       grp_gate_en;
      logic       cnt5_en;
      logic       irq_en;
      logic       dac_hi;
      logic [1:0] gate;
      logic [1:0] integ;
   } param_t;
endpackage

// File: rtl/rxcard_dac_stage.sv
module rxcard_dac_stage #(
   parameter int unsigned DW      = 8,
   parameter int unsigned DAC_W   = 12,
   parameter logic [DAC_W-1:0] RST_VAL = 12'h800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             hi_sel,
   input  logic [DW-1:0]    wdata,
   output logic [DAC_W-1:0] dac_out
);
   localparam int unsigned HI_W = DAC_W - DW;

   generate
      if (DAC_W <= DW || DAC_W > 2*DW) begin : g_bad_width
         $error("DAC width must lie between one and two bus bytes");
      end
   endgenerate

   logic [DW-1:0]    lo_q;
   logic [DAC_W-1:0] out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= RST_VAL[DW-1:0];
         out_q <= RST_VAL;
      end else if (wr) begin
         if (hi_sel) out_q <= {wdata[HI_W-1:0], lo_q};
         else        lo_q  <= wdata;
      end
   end

   assign dac_out = out_q;

   // R3: the output only moves on a high-half write
   p_dac_atomic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && hi_sel) |=> $stable(dac_out));
endmodule

// File: rtl/rxcard_adc_ctl.sv
module rxcard_adc_ctl #(
   parameter int unsigned RES_W = 8,
   parameter int unsigned CH_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_wr,
   input  logic [CH_W-1:0]  chan_val,
   input  logic             start_wr,
   input  logic             start_bit,
   input  logic             result_rd,
   input  logic             adc_done_in,
   input  logic [RES_W-1:0] adc_result_in,
   output logic [CH_W-1:0]  adc_chan,
   output logic             adc_start,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result,
   output logic             irq_pend
);
   logic             busy_q, done_q, start_q, pend_q;
   logic [CH_W-1:0]  chan_q;
   logic [RES_W-1:0] result_q;
   logic             accept, finish;

   assign accept = start_wr && start_bit && !busy_q;
   assign finish = adc_done_in && busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         start_q  <= 1'b0;
         pend_q   <= 1'b0;
         chan_q   <= '0;
         result_q <= '0;
      end else begin
         start_q <= accept;
         if (chan_wr) chan_q <= chan_val;
         if (accept) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            pend_q <= 1'b0;
         end else if (finish) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            pend_q   <= 1'b1;
            result_q <= adc_result_in;
         end else if (result_rd) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign adc_chan  = chan_q;
   assign adc_start = start_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign result    = result_q;
   assign irq_pend  = pend_q;

   p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);
   p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(adc_done_in && busy) |=> $stable(result));
   p_pend_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend |-> done);
endmodule

// File: rtl/rxcard_regbank.sv
module rxcard_regbank
   import rxcard_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned DAC_W   = 12,
   parameter int unsigned RES_W   = 8,
   parameter int unsigned CH_W    = 2,
   parameter logic [DAC_W-1:0] DAC_RST = 12'h800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic             adc_done_in,
   input  logic [RES_W-1:0] adc_result_in,
   output logic [CH_W-1:0]  adc_chan,
   output logic             adc_start,
   output logic [1:0]       integ_sel,
   output logic [1:0]       gate_sel,
   output logic             dac_hi_sel,
   output logic             irq_en,
   output logic             cnt5_en,
   output logic             grp_gate_en,
   output logic [DAC_W-1:0] dac_a,
   output logic [DAC_W-1:0] dac_b,
   output logic [DW-1:0]    pcode,
   output logic             irq
);
   localparam int unsigned N_DAC = 2;

   generate
      if (DW != $bits(param_t)) begin : g_bad_dw
         $error("bus width must match the parameter byte");
      end
      if (RES_W > DW || CH_W > DW || DW < 2) begin : g_bad_res
         $error("result and channel must fit on the bus");
      end
   endgenerate

   param_t        par_q;
   logic [DW-1:0] pcode_q;
   logic          busy, done, pend;
   logic [RES_W-1:0] result;
   logic [DAC_W-1:0] dac_val [N_DAC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q   <= '0;
         pcode_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == OFS_PARAM) par_q   <= param_t'(bus_wdata);
         if (bus_addr == OFS_PCODE) pcode_q <= bus_wdata;
      end
   end

   for (genvar i = 0; i < N_DAC; i++) begin : g_dac
      rxcard_dac_stage #(.DW(DW), .DAC_W(DAC_W), .RST_VAL(DAC_RST)) u_dac (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (bus_wr && bus_addr == OFS_DAC_BASE + 3'(i)),
         .hi_sel  (par_q.dac_hi),
         .wdata   (bus_wdata),
         .dac_out (dac_val[i])
      );
   end

   rxcard_adc_ctl #(.RES_W(RES_W), .CH_W(CH_W)) u_adc (
      .clk           (clk),
      .rst_n         (rst_n),
      .chan_wr       (bus_wr && bus_addr == OFS_ADC_DATA),
      .chan_val      (bus_wdata[CH_W-1:0]),
      .start_wr      (bus_wr && bus_addr == OFS_ADC_CTRL),
      .start_bit     (bus_wdata[0]),
      .result_rd     (bus_rd && bus_addr == OFS_ADC_DATA),
      .adc_done_in   (adc_done_in),
      .adc_result_in (adc_result_in),
      .adc_chan      (adc_chan),
      .adc_start     (adc_start),
      .busy          (busy),
      .done          (done),
      .result        (result),
      .irq_pend      (pend)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_ADC_DATA) begin
         bus_rdata[RES_W-1:0] = result;
      end else if (bus_addr == OFS_ADC_CTRL) begin
         bus_rdata[0]    = busy;
         bus_rdata[DW-1] = done;
      end
   end

   assign integ_sel   = par_q.integ;
   assign gate_sel    = par_q.gate;
   assign dac_hi_sel  = par_q.dac_hi;
   assign irq_en      = par_q.irq_en;
   assign cnt5_en     = par_q.cnt5_en;
   assign grp_gate_en = par_q.grp_gate_en;
   assign dac_a       = dac_val[0];
   assign dac_b       = dac_val[1];
   assign pcode       = pcode_q;
   assign irq         = pend && par_q.irq_en;

   p_param_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_PARAM) |=> $stable(par_q));
   p_pcode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_PCODE) |=> $stable(pcode));
   p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> bus_rdata_status_done);

   logic bus_rdata_status_done;
   assign bus_rdata_status_done = done;
endmodule

// File: tb/rxcard_regbank_tb_top.sv
module rxcard_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        adc_done_in = 1'b0;
   logic [7:0]  adc_result_in = '0;
   logic [1:0]  adc_chan, integ_sel, gate_sel;
   logic        adc_start, dac_hi_sel, irq_en, cnt5_en, grp_gate_en, irq;
   logic [11:0] dac_a, dac_b;
   logic [7:0]  pcode;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rxcard_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_done_in(adc_done_in),
      .adc_result_in(adc_result_in), .adc_chan(adc_chan), .adc_start(adc_start),
      .integ_sel(integ_sel), .gate_sel(gate_sel), .dac_hi_sel(dac_hi_sel), .irq_en(irq_en),
      .cnt5_en(cnt5_en), .grp_gate_en(grp_gate_en), .dac_a(dac_a), .dac_b(dac_b),
      .pcode(pcode), .irq(irq)
   );

   // {wdata, integ, gate, {grp, cnt5, ien, hi}}
   localparam int NV = 6;
   localparam logic [15:0] VEC [NV] = '{
      {8'h00, 2'd0, 2'd0, 4'b0000},
      {8'hFF, 2'd3, 2'd3, 4'b1111},
      {8'h5A, 2'd2, 2'd2, 4'b0101},
      {8'hA5, 2'd1, 2'd1, 4'b1010},
      {8'h13, 2'd3, 2'd0, 4'b0001},
      {8'hEC, 2'd0, 2'd3, 4'b1110}
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic adc_finish(input logic [7:0] v);
      @(negedge clk);
      adc_done_in = 1'b1; adc_result_in = v;
      @(posedge clk);
      @(negedge clk);
      adc_done_in = 1'b0;
   endtask

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 dac_a", 16'(dac_a), 16'h800);
      check("R10 dac_b", 16'(dac_b), 16'h800);
      check("R10 pcode", 16'(pcode), 16'h0);
      check("R10 params", 16'({integ_sel, gate_sel, grp_gate_en, cnt5_en, irq_en, dac_hi_sel}), 16'h0);
      check("R10 chan/start/irq", 16'({adc_chan, adc_start, irq}), 16'h0);
      bus_read(3'd3, rd);
      check("R10 status", 16'(rd), 16'h0);

      // R1 parameter table
      for (int i = 0; i < NV; i++) begin
         bus_write(3'd7, VEC[i][15:8]);
         check("R1 integ", 16'(integ_sel), 16'(VEC[i][7:6]));
         check("R1 gate", 16'(gate_sel), 16'(VEC[i][5:4]));
         check("R1 flags", 16'({grp_gate_en, cnt5_en, irq_en, dac_hi_sel}), 16'(VEC[i][3:0]));
      end
      bus_write(3'd6, 8'h00);
      check("R1 param unchanged by other offset", 16'({integ_sel, gate_sel}), 16'b0011);

      // R2/R3 DAC sequencing
      bus_write(3'd7, 8'h00);
      bus_write(3'd4, 8'h34);
      check("R2 dac_a held after low write", 16'(dac_a), 16'h800);
      bus_write(3'd7, 8'h10);
      bus_write(3'd4, 8'hF7);
      check("R3 dac_a loaded", 16'(dac_a), 16'h734);
      check("R3 dac_b untouched", 16'(dac_b), 16'h800);
      bus_write(3'd7, 8'h00);
      bus_write(3'd5, 8'hCD);
      check("R2 dac_b held after low write", 16'(dac_b), 16'h800);
      bus_write(3'd7, 8'h10);
      bus_write(3'd5, 8'h01);
      check("R3 dac_b loaded", 16'(dac_b), 16'h1CD);
      check("R3 dac_a untouched", 16'(dac_a), 16'h734);
      bus_write(3'd4, 8'h0A);
      check("R3 reuse pending low", 16'(dac_a), 16'hA34);

      // R9 pulse code, R11 write-only reads
      bus_write(3'd6, 8'hCA);
      check("R9 pcode", 16'(pcode), 16'hCA);
      bus_read(3'd6, rd); check("R11 read 6", 16'(rd), 16'h0);
      bus_read(3'd7, rd); check("R11 read 7", 16'(rd), 16'h0);
      bus_read(3'd0, rd); check("R11 read 0", 16'(rd), 16'h0);
      bus_read(3'd4, rd); check("R11 read 4", 16'(rd), 16'h0);

      // R4 channel
      bus_write(3'd2, 8'h01); check("R4 chan Q", 16'(adc_chan), 16'd1);
      bus_write(3'd2, 8'hFE); check("R4 chan S", 16'(adc_chan), 16'd2);

      // R5 start
      bus_write(3'd3, 8'h00);
      check("R5 no start on bit0=0", 16'(adc_start), 16'd0);
      bus_read(3'd3, rd); check("R5 status idle", 16'(rd), 16'h00);
      bus_write(3'd7, 8'h20);
      bus_write(3'd3, 8'h01);
      check("R5 start pulse", 16'(adc_start), 16'd1);
      @(negedge clk);
      check("R5 start one cycle", 16'(adc_start), 16'd0);
      bus_read(3'd3, rd); check("R6 status busy", 16'(rd), 16'h01);

      // R7 start while busy ignored
      bus_write(3'd3, 8'h01);
      check("R7 no pulse while busy", 16'(adc_start), 16'd0);
      bus_read(3'd3, rd); check("R7 still busy", 16'(rd), 16'h01);

      // R6/R8 completion
      adc_finish(8'h9C);
      check("R8 irq raised", 16'(irq), 16'd1);
      bus_read(3'd3, rd); check("R6 status done", 16'(rd), 16'h80);
      bus_read(3'd2, rd); check("R6 result", 16'(rd), 16'h9C);
      check("R8 irq cleared by read", 16'(irq), 16'd0);
      adc_finish(8'h55);
      bus_read(3'd2, rd); check("R7 result held when idle", 16'(rd), 16'h9C);

      // R8 gating by enable
      bus_write(3'd7, 8'h00);
      bus_write(3'd3, 8'h01);
      adc_finish(8'h11);
      check("R8 irq masked", 16'(irq), 16'd0);
      bus_write(3'd7, 8'h20);
      check("R8 irq after enable", 16'(irq), 16'd1);
      bus_write(3'd3, 8'h01);
      check("R8 irq cleared by start", 16'(irq), 16'd0);
      bus_read(3'd3, rd); check("R5 done cleared on start", 16'(rd), 16'h01);
      bus_read(3'd2, rd); check("R7 result kept during conversion", 16'(rd), 16'h11);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule